// File: doc/BRIEF.md
# Reference Clock Switch Handshake Sequencer

This block moves a serial video transmitter from one reference clock rate to the other. A requester pulses a switch strobe together with the wanted rate select and the current video standard. The sequencer then runs the handshake with a transceiver reconfiguration controller. It drives the PLL select line first and raises the reconfiguration start request after it. It holds both until the controller reports done. It then drops start and issues a transmitter reset pulse. The new rate counts as in effect only once that reset has been released.

Select value 0 picks the primary reference (148.5 MHz rate). Select value 1 picks the alternate reference (148.35 MHz rate). Requests made while the transmitter runs standard definition are refused. Requests for the rate already in use finish at once with no handshake. A request that reverses the pending select before start is raised cancels the switch. If done never arrives, a timeout abandons the handshake and puts the old select back. Rejections, requests that arrive while busy, and timeouts all set one sticky error flag, which a clear input resets.

Top module: `refclk_switch_seq`

## Requirements
- R1: After reset, `pll_sel_o` and `rate_sel_o` equal `INIT_SEL` (default 0, where 0 is the primary 148.5 MHz reference and 1 is the alternate 148.35 MHz one), and `start_o`, `txrst_o`, `busy_o` and `err_o` are low.
- R2: When a switch is accepted, `pll_sel_o` takes the requested value and `busy_o` rises in the cycle after the strobe. With `START_LAG`=1 (default), `start_o` rises one cycle later. `start_o` never rises while `pll_sel_o` still equals the rate in use.
- R3: `start_o` stays high without a break until `done_i` is sampled high, and `pll_sel_o` does not change while `start_o` is high.
- R4: In the cycle after `done_i` is sampled high with `start_o` high, `start_o` is low and `txrst_o` is high. `txrst_o` then stays high for exactly `RST_W` cycles (default 4).
- R5: `busy_o` stays high from acceptance until the cycle in which `txrst_o` falls. `rate_sel_o` takes the new select in that same cycle and changes at no other time.
- R6: A strobe with `std_i` = 2'b00 (standard definition) is rejected. Select, start and busy stay unchanged, and `err_o` is set.
- R7: A strobe while `busy_o` is high does not alter the handshake in progress and sets `err_o`. `err_o` stays set until `clr_err_i` is pulsed, and a new error has priority over a clear in the same cycle.
- R8: If `start_o` has been high for `TIMEOUT` cycles (default 16) without `done_i`, `start_o` drops, `pll_sel_o` returns to `rate_sel_o`, `err_o` is set, `busy_o` falls, and no reset pulse is issued.
- R9: A strobe during the arming cycle whose select differs from the pending one cancels the switch. `pll_sel_o` returns to the rate in use, `start_o` never rises, and `err_o` is not set.
- R10: A strobe for a non-SD standard whose select equals `rate_sel_o` completes immediately. `busy_o`, `start_o` and `err_o` all stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Switch request strobe |
| req_sel_i | input | 1 | Requested reference select (0 primary, 1 alternate) |
| std_i | input | 2 | Current video standard, 2'b00 = standard definition |
| done_i | input | 1 | Reconfiguration done from the controller |
| clr_err_i | input | 1 | Clears the sticky error flag |
| pll_sel_o | output | 1 | Held PLL reference select |
| start_o | output | 1 | Reconfiguration start request |
| txrst_o | output | 1 | Transmitter reset pulse |
| busy_o | output | 1 | Handshake in progress |
| err_o | output | 1 | Sticky error flag |
| rate_sel_o | output | 1 | Reference rate currently in effect |

## Verification
A wrong state in the sequencer reaches the ports within one cycle. A bad transition shows up as a start request with the select unchanged, as a start that drops before done, or as a reset that arrives without a preceding done. An off-by-one in the timeout or reset counters appears only at the end of the window. It is caught by counting the exact number of cycles that `start_o` or `txrst_o` stays high. A rate register that updates too early shows as `rate_sel_o` changing while `txrst_o` is still high.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT,
    ST_RST
  } rsq_state_e;

  localparam int          STD_W  = 2;
  localparam logic [1:0]  STD_SD = 2'b00;

  // true when the video standard forbids a rate change
  function automatic logic is_sd(input logic [STD_W-1:0] std);
    return std == STD_SD;
  endfunction

  // true on the last permitted wait cycle of a window of lim cycles
  function automatic logic at_limit(input logic [31:0] cnt, input int unsigned lim);
    return (cnt + 32'd1) >= lim;
  endfunction

endpackage

// File: rtl/rsq_rst_pulse.sv
module rsq_rst_pulse #(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o,
  output logic fin_o
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (fire_i) begin
      cnt_q <= CW'(WIDTH);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign pulse_o = (cnt_q != '0);
  assign fin_o   = (cnt_q == CW'(1));

endmodule

// File: rtl/rsq_err_flag.sv
module rsq_err_flag #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic             clr_i,
  output logic             err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (|set_i) begin
      err_q <= 1'b1;
    end else if (clr_i) begin
      err_q <= 1'b0;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import rsq_pkg::*;
#(
  parameter int unsigned START_LAG = 1,
  parameter int unsigned TIMEOUT   = 16,
  parameter logic        INIT_SEL  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_sel_i,
  input  logic [STD_W-1:0] std_i,
  input  logic             done_i,
  input  logic             rst_fin_i,
  output rsq_state_e       state_o,
  output logic             pll_sel_o,
  output logic             start_o,
  output logic             rate_sel_o,
  output logic             fire_o,
  output logic             evt_reject_o,
  output logic             evt_same_o,
  output logic             evt_busyreq_o,
  output logic             evt_timeout_o,
  output logic             evt_revert_o
);
  localparam int TW = $clog2(TIMEOUT + 1);

  rsq_state_e state_q;
  rsq_state_e accept_next;
  logic       sel_q;
  logic       rate_q;
  logic [TW-1:0] tcnt_q;
  logic       idle;
  logic       accept;

  generate
    if (START_LAG == 0) begin : g_no_lag
      assign accept_next = ST_WAIT;
    end else begin : g_lag
      assign accept_next = ST_ARM;
    end
  endgenerate

  assign idle          = (state_q == ST_IDLE);
  assign evt_reject_o  = idle && req_i && is_sd(std_i);
  assign evt_same_o    = idle && req_i && !is_sd(std_i) && (req_sel_i == rate_q);
  assign accept        = idle && req_i && !is_sd(std_i) && (req_sel_i != rate_q);
  assign evt_revert_o  = (state_q == ST_ARM) && req_i && (req_sel_i != sel_q);
  assign evt_busyreq_o = !idle && req_i && !evt_revert_o;
  assign fire_o        = (state_q == ST_WAIT) && done_i;
  assign evt_timeout_o = (state_q == ST_WAIT) && !done_i && at_limit(32'(tcnt_q), TIMEOUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= INIT_SEL;
      rate_q  <= INIT_SEL;
      tcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sel_q   <= req_sel_i;
            state_q <= accept_next;
            tcnt_q  <= '0;
          end
        end
        ST_ARM: begin
          if (evt_revert_o) begin
            sel_q   <= rate_q;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_WAIT;
            tcnt_q  <= '0;
          end
        end
        ST_WAIT: begin
          if (fire_o) begin
            state_q <= ST_RST;
          end else if (evt_timeout_o) begin
            sel_q   <= rate_q;
            state_q <= ST_IDLE;
          end else begin
            tcnt_q <= tcnt_q + TW'(1);
          end
        end
        default: begin
          if (rst_fin_i) begin
            rate_q  <= sel_q;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign state_o    = state_q;
  assign pll_sel_o  = sel_q;
  assign start_o    = (state_q == ST_WAIT);
  assign rate_sel_o = rate_q;

endmodule

// File: rtl/refclk_switch_seq.sv
module refclk_switch_seq
  import rsq_pkg::*;
#(
  parameter int unsigned START_LAG = 1,
  parameter int unsigned TIMEOUT   = 16,
  parameter int unsigned RST_W     = 4,
  parameter logic        INIT_SEL  = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       req_sel_i,
  input  logic [1:0] std_i,
  input  logic       done_i,
  input  logic       clr_err_i,
  output logic       pll_sel_o,
  output logic       start_o,
  output logic       txrst_o,
  output logic       busy_o,
  output logic       err_o,
  output logic       rate_sel_o
);
  rsq_state_e state;
  logic fire;
  logic rst_fin;
  logic evt_reject;
  logic evt_same;
  logic evt_busyreq;
  logic evt_timeout;
  logic evt_revert;

  rsq_fsm #(
    .START_LAG (START_LAG),
    .TIMEOUT   (TIMEOUT),
    .INIT_SEL  (INIT_SEL)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .req_sel_i     (req_sel_i),
    .std_i         (std_i),
    .done_i        (done_i),
    .rst_fin_i     (rst_fin),
    .state_o       (state),
    .pll_sel_o     (pll_sel_o),
    .start_o       (start_o),
    .rate_sel_o    (rate_sel_o),
    .fire_o        (fire),
    .evt_reject_o  (evt_reject),
    .evt_same_o    (evt_same),
    .evt_busyreq_o (evt_busyreq),
    .evt_timeout_o (evt_timeout),
    .evt_revert_o  (evt_revert)
  );

  rsq_rst_pulse #(
    .WIDTH (RST_W)
  ) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .pulse_o (txrst_o),
    .fin_o   (rst_fin)
  );

  rsq_err_flag #(
    .N_SRC (3)
  ) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({evt_reject, evt_busyreq, evt_timeout}),
    .clr_i  (clr_err_i),
    .err_o  (err_o)
  );

  assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/rsq_chk.sv
module rsq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [1:0] std_i,
  input logic       done_i,
  input logic       pll_sel_o,
  input logic       start_o,
  input logic       txrst_o,
  input logic       busy_o,
  input logic       err_o,
  input logic       rate_sel_o,
  input logic       fire,
  input logic       evt_reject,
  input logic       evt_same,
  input logic       evt_timeout,
  input logic       evt_revert
);

  assert_select_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> (pll_sel_o != rate_sel_o));

  assert_start_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !done_i && !evt_timeout) |=> start_o);

  assert_sel_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && $past(start_o)) |-> (pll_sel_o == $past(pll_sel_o)));

  assert_drop_on_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && done_i) |=> (!start_o && txrst_o));

  assert_busy_covers_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txrst_o |-> busy_o);

  assert_rate_at_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_o != $past(rate_sel_o)) |-> ($past(txrst_o) && !txrst_o));

  assert_sd_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && std_i == 2'b00) |=> (!busy_o && err_o));

  assert_timeout_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_timeout |=> (!start_o && !txrst_o && !busy_o && err_o && pll_sel_o == rate_sel_o));

  assert_revert_clean_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_revert |=> (!busy_o && !start_o && pll_sel_o == rate_sel_o));

  assert_events_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_reject, evt_same, evt_timeout, evt_revert, fire}));

endmodule

bind refclk_switch_seq rsq_chk u_chk (.*);

// File: tb/sim_refclk_switch_seq.sv
`timescale 1ns/1ps
module sim_refclk_switch_seq;
  localparam int RST_W   = 4;
  localparam int TIMEOUT = 16;
  localparam int NVEC    = 6;
  // {std[1:0], select, done delay[4:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    {2'b01, 1'b1, 5'd3},
    {2'b10, 1'b1, 5'd2},
    {2'b00, 1'b0, 5'd1},
    {2'b11, 1'b0, 5'd0},
    {2'b01, 1'b0, 5'd4},
    {2'b10, 1'b1, 5'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_sel = 1'b0, done = 1'b0, clr = 1'b0;
  logic [1:0] std = 2'b01;
  logic pll_sel, start, txrst, busy, err, rate;
  int checks = 0, failures = 0;
  logic model_rate = 1'b0;

  always #2.5 clk = ~clk;

  refclk_switch_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_sel_i(req_sel),
    .std_i(std), .done_i(done), .clr_err_i(clr),
    .pll_sel_o(pll_sel), .start_o(start), .txrst_o(txrst),
    .busy_o(busy), .err_o(err), .rate_sel_o(rate)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_err();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk("R7 clear", int'(err), 0);
  endtask

  task automatic strobe(input logic [1:0] s, input logic v);
    @(negedge clk);
    req = 1'b1; req_sel = v; std = s;
    @(negedge clk);
    req = 1'b0;
  endtask

  // full handshake from the arming cycle onward, partner answers after dly cycles
  task automatic finish_switch(input logic tgt, input int dly);
    chk("R2 sel set", int'(pll_sel), int'(tgt));
    chk("R2 start waits", int'(start), 0);
    chk("R5 busy", int'(busy), 1);
    @(negedge clk);
    chk("R2 start", int'(start), 1);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R3 start held", int'(start), 1);
      chk("R3 sel held", int'(pll_sel), int'(tgt));
    end
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R4 start drop", int'(start), 0);
    chk("R4 txrst", int'(txrst), 1);
    chk("R5 rate old", int'(rate), int'(model_rate));
    for (int i = 1; i < RST_W; i++) begin
      @(negedge clk);
      chk("R4 txrst width", int'(txrst), 1);
      chk("R5 busy in rst", int'(busy), 1);
    end
    @(negedge clk);
    chk("R4 txrst end", int'(txrst), 0);
    chk("R5 busy end", int'(busy), 0);
    chk("R5 rate new", int'(rate), int'(tgt));
    model_rate = tgt;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sel", int'(pll_sel), 0);
    chk("R1 start", int'(start), 0);
    chk("R1 txrst", int'(txrst), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 rate", int'(rate), 0);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      logic [1:0] s;
      logic v;
      int d;
      s = VEC[k][7:6];
      v = VEC[k][5];
      d = int'(VEC[k][4:0]);
      strobe(s, v);
      if (s == 2'b00) begin
        chk("R6 reject busy", int'(busy), 0);
        chk("R6 reject sel", int'(pll_sel), int'(model_rate));
        chk("R6 reject err", int'(err), 1);
        @(negedge clk);
        chk("R6 no start", int'(start), 0);
        clear_err();
      end else if (v == model_rate) begin
        chk("R10 same busy", int'(busy), 0);
        chk("R10 same err", int'(err), 0);
        @(negedge clk);
        chk("R10 same start", int'(start), 0);
        chk("R10 same sel", int'(pll_sel), int'(model_rate));
      end else begin
        finish_switch(v, d);
      end
    end

    // R8: controller never answers
    begin
      int n;
      logic tgt;
      tgt = ~model_rate;
      strobe(2'b01, tgt);
      chk("R8 armed", int'(pll_sel), int'(tgt));
      n = 0;
      @(negedge clk);
      while (start && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk("R8 start cycles", n, TIMEOUT);
      chk("R8 sel restored", int'(pll_sel), int'(model_rate));
      chk("R8 err", int'(err), 1);
      chk("R8 busy", int'(busy), 0);
      chk("R8 no txrst", int'(txrst), 0);
      chk("R8 rate kept", int'(rate), int'(model_rate));
      clear_err();
    end

    // R9: select reverts during the arming cycle
    @(negedge clk);
    req = 1'b1; req_sel = ~model_rate; std = 2'b10;
    @(negedge clk);
    req_sel = model_rate;
    @(negedge clk);
    req = 1'b0;
    chk("R9 sel back", int'(pll_sel), int'(model_rate));
    chk("R9 busy", int'(busy), 0);
    chk("R9 err", int'(err), 0);
    @(negedge clk);
    chk("R9 no start", int'(start), 0);
    chk("R9 rate kept", int'(rate), int'(model_rate));

    // R7: request during the wait phase
    begin
      logic tgt;
      tgt = ~model_rate;
      strobe(2'b01, tgt);
      @(negedge clk);
      chk("R7 start", int'(start), 1);
      req = 1'b1; req_sel = ~tgt;
      @(negedge clk);
      req = 1'b0;
      chk("R7 err set", int'(err), 1);
      chk("R7 start kept", int'(start), 1);
      chk("R7 sel kept", int'(pll_sel), int'(tgt));
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk("R4 txrst after busy req", int'(txrst), 1);
      repeat (RST_W) @(negedge clk);
      chk("R5 rate after busy req", int'(rate), int'(tgt));
      model_rate = tgt;
      chk("R7 err sticky", int'(err), 1);
      // new error wins over a clear in the same cycle
      req = 1'b1; req_sel = 1'b0; std = 2'b00; clr = 1'b1;
      @(negedge clk);
      req = 1'b0; clr = 1'b0;
      chk("R7 set beats clear", int'(err), 1);
      clear_err();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule